// File: doc/BRIEF.md
# Local Interrupt Controller Register Bank

This block is the memory-mapped register bank of a local interrupt controller. A bus master presents a byte offset, an access size in bytes and, for writes, the data. The block aligns the offset down to an 8-byte window, decodes the window to one register, applies that register's write rule and returns the read data or an access-error flag one cycle later.

Every register has its own write rule. Some fields are clipped to a byte or to the top byte. One register has its low 28 bits forced to ones. Some fields are read-only status bits that keep their old value. The divide register keeps only three bits. The error-status register takes two writes to clear: the first write only arms it and the second write clears it, and a read in between cancels the arm. A write to the end-of-interrupt location stores nothing and instead sends a single-cycle strobe to the priority logic. Register contents are exported as plain signals to neighbouring blocks. Error bits from those blocks are merged into the error-status register, and the running timer count comes in from the timer block.

The interrupt-command registers, the arbitration and processor priority registers and the request, in-service and trigger arrays are decoded as unmapped, so any access to them reports an error.

Top module: `lic_regbank`

## Requirements
- R1: The offset is aligned down to a multiple of 8 before decoding. The mapped windows are 0x20 id, 0x30 version, 0x80 task priority, 0xB0 end-of-interrupt, 0xD0 logical destination, 0xE0 destination format, 0xF0 spurious vector, 0x280 error status, 0x320 + 0x10*i for local vector table entry i (i = 0..5), 0x380 initial count, 0x390 current count and 0x3E0 divide. Any other window sets `acc_err`, changes no state and returns read data 0.
- R2: The access size is a byte count. It is legal when it is 1..4 and when (offset mod 8) + size ≤ 8. Otherwise `acc_err` is set and no state changes. The low three offset bits select the starting byte of the window. The register occupies window bytes 0..3, so window bytes 4..7 read as zero and writes to them are ignored. Read byte k of the bus carries window byte (lane + k).
- R3: `acc_rdata` and `acc_err` are registered. They describe the access presented in the previous cycle and are zero in any cycle that follows an idle cycle.
- R4: After reset every register reads zero, except the version register, which reads `VERSION_VAL`, and the current count, which reads `cur_count_in`.
- R5: A write to id or task priority keeps only bits 7:0. A write to logical destination keeps only bits 31:24.
- R6: A write to destination format stores the written value with bits 27:0 forced to one.
- R7: Writes to version and current count are dropped without error. Current count always reads `cur_count_in`.
- R8: In each vector table entry, bits 12 and 14 are read-only and keep their value across writes. All other bits store the written value.
- R9: A write to divide keeps only bits 3, 1 and 0 (mask 0xB).
- R10: A write to the spurious vector register stores the full value, and `exp_sw_en` takes bit 8 of that value.
- R11: `err_set` bits are ORed into error status every cycle. A legal write to error status while it is not armed sets the arm flag and leaves the value unchanged. A legal write while armed clears the value and the flag. A legal read of error status clears the flag.
- R12: A legal write to end-of-interrupt raises `eoi_pulse` for exactly the following cycle and stores nothing; the location reads zero. A read of it gives no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access presented this cycle |
| acc_write | input | 1 | 1 write, 0 read |
| acc_addr | input | ADDR_W | Byte offset |
| acc_size | input | 4 | Access size in bytes |
| acc_wdata | input | DATA_W | Write data, byte 0 first |
| acc_rdata | output | DATA_W | Read data of the previous access |
| acc_err | output | 1 | Previous access was unmapped or badly sized |
| err_set | input | ESR_W | Error bits merged into error status |
| cur_count_in | input | 32 | Running count from the timer |
| eoi_pulse | output | 1 | End-of-interrupt strobe |
| exp_id | output | 8 | Id register |
| exp_tpr | output | 8 | Task priority |
| exp_ldr | output | 32 | Logical destination |
| exp_dfr | output | 32 | Destination format |
| exp_sw_en | output | 1 | Software enable |
| exp_esr | output | ESR_W | Error status |
| exp_lvt | output | 32*NUM_LVT | Vector table entries, entry 0 lowest |
| exp_init | output | 32 | Initial count |
| exp_div | output | 4 | Divide configuration |

## Verification
The assertions assume that `acc_addr` and `acc_size` carry no unknowns while `acc_valid` is high, and that inputs change only between clock edges. The stimulus drives every access on the falling edge, holds it for one full cycle and then returns `acc_valid` to zero. The two-write clear property also assumes that `err_set` is quiet across the two writes it looks at. The bench raises `err_set` only in isolated pulses, well away from any error-status write.

// File: rtl/lic_pkg.sv
package lic_pkg;
   localparam int WIN_BYTES = 8;
   localparam int REG_BYTES = 4;
   localparam int MAX_LVT   = 6;

   typedef enum logic [3:0] {
      RG_NONE, RG_ID, RG_VER, RG_TPR, RG_EOI, RG_LDR, RG_DFR,
      RG_SVR, RG_ESR, RG_LVT, RG_INIT, RG_CUR, RG_DIV
   } lic_reg_e;

   localparam logic [31:0] LVT_RO_MASK = 32'h0000_5000;
   localparam logic [31:0] LDR_KEEP    = 32'hFF00_0000;
   localparam logic [31:0] DFR_FILL    = 32'h0FFF_FFFF;
   localparam logic [3:0]  DIV_KEEP    = 4'hB;

   localparam logic [31:0] LVT_BASE = 32'h320;
   localparam logic [31:0] LVT_STEP = 32'h10;
endpackage

// File: rtl/lic_decode.sv
module lic_decode
   import lic_pkg::*;
#(
   parameter int ADDR_W  = 12,
   parameter int NUM_LVT = 6
) (
   input  logic [ADDR_W-1:0] addr,
   output lic_reg_e          sel,
   output logic [2:0]        lvt_idx
);
   logic [31:0] base;

   always_comb begin
      base    = 32'(addr) & ~32'h7;
      sel     = RG_NONE;
      lvt_idx = '0;
      case (base)
         32'h020: sel = RG_ID;
         32'h030: sel = RG_VER;
         32'h080: sel = RG_TPR;
         32'h0B0: sel = RG_EOI;
         32'h0D0: sel = RG_LDR;
         32'h0E0: sel = RG_DFR;
         32'h0F0: sel = RG_SVR;
         32'h280: sel = RG_ESR;
         32'h380: sel = RG_INIT;
         32'h390: sel = RG_CUR;
         32'h3E0: sel = RG_DIV;
         default: sel = RG_NONE;
      endcase
      for (int i = 0; i < NUM_LVT; i++) begin
         if (base == LVT_BASE + LVT_STEP * 32'(i)) begin
            sel     = RG_LVT;
            lvt_idx = 3'(i);
         end
      end
   end
endmodule

// File: rtl/lic_lane.sv
module lic_lane
   import lic_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic [2:0]        lane,
   input  logic [3:0]        size,
   input  logic [DATA_W-1:0] wdata,
   input  logic [31:0]       cur,
   output logic [31:0]       merged,
   output logic [DATA_W-1:0] rdata,
   output logic              fits
);
   localparam int BUS_BYTES = DATA_W / 8;

   always_comb begin
      fits   = (size != 4'd0) && (int'(size) <= BUS_BYTES)
               && (int'(lane) + int'(size) <= WIN_BYTES);
      merged = cur;
      rdata  = '0;
      for (int b = 0; b < REG_BYTES; b++) begin
         int k;
         k = b - int'(lane);
         if (k >= 0 && k < int'(size) && k < BUS_BYTES)
            merged[8*b +: 8] = wdata[8*k +: 8];
      end
      for (int k = 0; k < BUS_BYTES; k++) begin
         int b;
         b = int'(lane) + k;
         if (k < int'(size) && b < REG_BYTES)
            rdata[8*k +: 8] = cur[8*b +: 8];
      end
   end
endmodule

// File: rtl/lic_regbank.sv
module lic_regbank
   import lic_pkg::*;
#(
   parameter int          ADDR_W      = 12,
   parameter int          DATA_W      = 32,
   parameter int          NUM_LVT     = 6,
   parameter int          ESR_W       = 8,
   parameter logic [31:0] VERSION_VAL = 32'h0005_0014
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  acc_valid,
   input  logic                  acc_write,
   input  logic [ADDR_W-1:0]     acc_addr,
   input  logic [3:0]            acc_size,
   input  logic [DATA_W-1:0]     acc_wdata,
   output logic [DATA_W-1:0]     acc_rdata,
   output logic                  acc_err,
   input  logic [ESR_W-1:0]      err_set,
   input  logic [31:0]           cur_count_in,
   output logic                  eoi_pulse,
   output logic [7:0]            exp_id,
   output logic [7:0]            exp_tpr,
   output logic [31:0]           exp_ldr,
   output logic [31:0]           exp_dfr,
   output logic                  exp_sw_en,
   output logic [ESR_W-1:0]      exp_esr,
   output logic [32*NUM_LVT-1:0] exp_lvt,
   output logic [31:0]           exp_init,
   output logic [3:0]            exp_div
);
   generate
      if (DATA_W != 32 && DATA_W != 64) begin : g_bad_data
         $error("lic_regbank: DATA_W must be 32 or 64");
      end
      if (NUM_LVT < 1 || NUM_LVT > MAX_LVT) begin : g_bad_lvt
         $error("lic_regbank: NUM_LVT out of range");
      end
      if (ADDR_W < 10 || ADDR_W > 31) begin : g_bad_addr
         $error("lic_regbank: ADDR_W must be 10..31");
      end
      if (ESR_W < 1 || ESR_W > 32) begin : g_bad_esr
         $error("lic_regbank: ESR_W must be 1..32");
      end
   endgenerate

   lic_reg_e          sel;
   logic [2:0]        lvt_idx;
   logic [31:0]       cur_val;
   logic [31:0]       merged;
   logic [DATA_W-1:0] lane_rdata;
   logic              fits;
   logic              legal, wr_en, rd_en;

   logic [31:0] svr_q;
   logic [31:0] lvt_q [NUM_LVT];
   logic        esr_armed;

   lic_decode #(.ADDR_W(ADDR_W), .NUM_LVT(NUM_LVT)) u_dec (
      .addr    (acc_addr),
      .sel     (sel),
      .lvt_idx (lvt_idx)
   );

   lic_lane #(.DATA_W(DATA_W)) u_lane (
      .lane   (acc_addr[2:0]),
      .size   (acc_size),
      .wdata  (acc_wdata),
      .cur    (cur_val),
      .merged (merged),
      .rdata  (lane_rdata),
      .fits   (fits)
   );

   assign legal = acc_valid && fits && (sel != RG_NONE);
   assign wr_en = legal && acc_write;
   assign rd_en = legal && !acc_write;

   // Current value of the selected register.
   always_comb begin
      cur_val = '0;
      case (sel)
         RG_ID:   cur_val = {24'h0, exp_id};
         RG_VER:  cur_val = VERSION_VAL;
         RG_TPR:  cur_val = {24'h0, exp_tpr};
         RG_LDR:  cur_val = exp_ldr;
         RG_DFR:  cur_val = exp_dfr;
         RG_SVR:  cur_val = svr_q;
         RG_ESR:  cur_val = 32'(exp_esr);
         RG_INIT: cur_val = exp_init;
         RG_CUR:  cur_val = cur_count_in;
         RG_DIV:  cur_val = {28'h0, exp_div};
         RG_LVT: begin
            for (int i = 0; i < NUM_LVT; i++)
               if (lvt_idx == 3'(i)) cur_val = lvt_q[i];
         end
         default: cur_val = '0;
      endcase
   end

   // Plain registers with their own write rules.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         exp_id    <= '0;
         exp_tpr   <= '0;
         exp_ldr   <= '0;
         exp_dfr   <= '0;
         svr_q     <= '0;
         exp_sw_en <= 1'b0;
         exp_init  <= '0;
         exp_div   <= '0;
      end else if (wr_en) begin
         case (sel)
            RG_ID:   exp_id  <= merged[7:0];
            RG_TPR:  exp_tpr <= merged[7:0];
            RG_LDR:  exp_ldr <= merged & LDR_KEEP;
            RG_DFR:  exp_dfr <= merged | DFR_FILL;
            RG_SVR: begin
               svr_q     <= merged;
               exp_sw_en <= merged[8];
            end
            RG_INIT: exp_init <= merged;
            RG_DIV:  exp_div  <= merged[3:0] & DIV_KEEP;
            default: ;
         endcase
      end
   end

   // Vector table entries: read-only status bits keep their value.
   generate
      for (genvar gi = 0; gi < NUM_LVT; gi++) begin : g_lvt
         always_ff @(posedge clk) begin
            if (!rst_n)
               lvt_q[gi] <= '0;
            else if (wr_en && sel == RG_LVT && lvt_idx == 3'(gi))
               lvt_q[gi] <= (merged & ~LVT_RO_MASK) | (lvt_q[gi] & LVT_RO_MASK);
         end
         assign exp_lvt[32*gi +: 32] = lvt_q[gi];
      end
   endgenerate

   // Error status: external bits accumulate, clearing needs arm then clear.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         exp_esr   <= '0;
         esr_armed <= 1'b0;
      end else begin
         if (wr_en && sel == RG_ESR && esr_armed) begin
            exp_esr   <= err_set;
            esr_armed <= 1'b0;
         end else begin
            exp_esr <= exp_esr | err_set;
            if (wr_en && sel == RG_ESR)
               esr_armed <= 1'b1;
            else if (rd_en && sel == RG_ESR)
               esr_armed <= 1'b0;
         end
      end
   end

   // Registered bus response and end-of-interrupt strobe.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc_rdata <= '0;
         acc_err   <= 1'b0;
         eoi_pulse <= 1'b0;
      end else begin
         acc_rdata <= rd_en ? lane_rdata : '0;
         acc_err   <= acc_valid && !legal;
         eoi_pulse <= wr_en && sel == RG_EOI;
      end
   end
endmodule

// File: rtl/lic_regbank_chk.sv
module lic_regbank_chk
   import lic_pkg::*;
#(
   parameter int          ADDR_W      = 12,
   parameter int          DATA_W      = 32,
   parameter int          NUM_LVT     = 6,
   parameter int          ESR_W       = 8,
   parameter logic [31:0] VERSION_VAL = 32'h0005_0014
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  acc_valid,
   input logic                  acc_write,
   input logic [ADDR_W-1:0]     acc_addr,
   input logic [3:0]            acc_size,
   input logic [DATA_W-1:0]     acc_wdata,
   input logic [DATA_W-1:0]     acc_rdata,
   input logic                  acc_err,
   input logic [ESR_W-1:0]      err_set,
   input logic                  eoi_pulse,
   input logic [31:0]           exp_ldr,
   input logic [31:0]           exp_dfr,
   input logic                  exp_sw_en,
   input logic [ESR_W-1:0]      exp_esr,
   input logic [32*NUM_LVT-1:0] exp_lvt,
   input logic [3:0]            exp_div
);
   localparam int BUS_BYTES = DATA_W / 8;

   logic [31:0] base;
   logic        size_ok;
   logic        esr_wr;

   assign base    = 32'(acc_addr) & ~32'h7;
   assign size_ok = (acc_size != 4'd0) && (int'(acc_size) <= BUS_BYTES)
                    && (int'(acc_addr[2:0]) + int'(acc_size) <= WIN_BYTES);
   assign esr_wr  = acc_valid && acc_write && size_ok && base == 32'h280;

   // R3
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_valid |=> (!acc_err && acc_rdata == '0));

   // R1
   unmapped_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && base == 32'h090) |=> acc_err);

   // R2
   straddle_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && (int'(acc_addr[2:0]) + int'(acc_size) > WIN_BYTES)) |=> acc_err);

   // R12
   eoi_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      eoi_pulse |-> $past(acc_valid && acc_write && size_ok && base == 32'h0B0));

   // R4
   version_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && !acc_write && base == 32'h030 && acc_addr[2:0] == 3'd0
       && acc_size == 4'd4) |=> acc_rdata[31:0] == VERSION_VAL);

   // R6
   dfr_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && acc_write && size_ok && base == 32'h0E0) |=> exp_dfr[27:0] == 28'hFFF_FFFF);

   // R5
   ldr_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      exp_ldr[23:0] == 24'h0);

   // R9
   div_hole_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !exp_div[2]);

   // R10
   sw_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && acc_write && size_ok && base == 32'h0F0 && acc_addr[2:0] == 3'd0
       && acc_size >= 4'd2) |=> exp_sw_en == $past(acc_wdata[8]));

   // R11
   esr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (esr_wr && $past(esr_wr) && err_set == '0 && $past(err_set) == '0)
      |=> exp_esr == '0);

   // R8
   generate
      for (genvar gi = 0; gi < NUM_LVT; gi++) begin : g_ro
         lvt_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $stable({exp_lvt[32*gi+14], exp_lvt[32*gi+12]}));
      end
   endgenerate
endmodule

bind lic_regbank lic_regbank_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_LVT(NUM_LVT),
   .ESR_W(ESR_W), .VERSION_VAL(VERSION_VAL)
) u_chk (
   .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
   .acc_addr(acc_addr), .acc_size(acc_size), .acc_wdata(acc_wdata),
   .acc_rdata(acc_rdata), .acc_err(acc_err), .err_set(err_set),
   .eoi_pulse(eoi_pulse), .exp_ldr(exp_ldr), .exp_dfr(exp_dfr),
   .exp_sw_en(exp_sw_en), .exp_esr(exp_esr), .exp_lvt(exp_lvt),
   .exp_div(exp_div)
);

// File: tb/lic_regbank_tb.sv
`timescale 1ns/1ps
module lic_regbank_tb;
   localparam logic [31:0] VER = 32'h0005_0014;
   localparam logic [31:0] CNT = 32'h1234_5678;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        acc_valid = 1'b0, acc_write = 1'b0;
   logic [11:0] acc_addr = '0;
   logic [3:0]  acc_size = '0;
   logic [31:0] acc_wdata = '0;
   logic [31:0] acc_rdata;
   logic        acc_err;
   logic [7:0]  err_set = '0;
   logic [31:0] cur_count_in = CNT;
   logic        eoi_pulse;
   logic [7:0]  exp_id, exp_tpr;
   logic [31:0] exp_ldr, exp_dfr, exp_init;
   logic        exp_sw_en;
   logic [7:0]  exp_esr;
   logic [191:0] exp_lvt;
   logic [3:0]  exp_div;

   int n_chk = 0, n_fail = 0;
   logic [31:0] got_data;
   logic        got_err, got_eoi;

   always #10 clk = ~clk;

   lic_regbank u_dut (
      .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
      .acc_addr(acc_addr), .acc_size(acc_size), .acc_wdata(acc_wdata),
      .acc_rdata(acc_rdata), .acc_err(acc_err), .err_set(err_set),
      .cur_count_in(cur_count_in), .eoi_pulse(eoi_pulse), .exp_id(exp_id),
      .exp_tpr(exp_tpr), .exp_ldr(exp_ldr), .exp_dfr(exp_dfr),
      .exp_sw_en(exp_sw_en), .exp_esr(exp_esr), .exp_lvt(exp_lvt),
      .exp_init(exp_init), .exp_div(exp_div)
   );

   function automatic bit mapped(int off);
      case (off)
         'h20, 'h30, 'h80, 'hB0, 'hD0, 'hE0, 'hF0, 'h280, 'h380, 'h390, 'h3E0: return 1'b1;
         default: return (off >= 'h320 && off <= 'h370 && (off % 16) == 0);
      endcase
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic acc(input logic w, input int a, input int sz, input logic [31:0] d);
      @(negedge clk);
      acc_valid = 1'b1; acc_write = w; acc_addr = 12'(a);
      acc_size = 4'(sz); acc_wdata = d;
      @(posedge clk); #1;
      got_data = acc_rdata; got_err = acc_err; got_eoi = eoi_pulse;
      @(negedge clk);
      acc_valid = 1'b0; acc_write = 1'b0;
   endtask

   task automatic pulse_err(input logic [7:0] v);
      @(negedge clk); err_set = v;
      @(negedge clk); err_set = '0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      #1;
      check("R3 idle after reset", {31'h0, acc_err}, 32'h0);

      // R4: reset values of all mapped windows
      for (int o = 'h20; o < 'h400; o += 8) begin
         if (mapped(o) && o != 'h280) begin
            acc(1'b0, o, 4, '0);
            check("R4 reset value", got_data, (o == 'h30) ? VER : (o == 'h390) ? CNT : 32'h0);
         end
      end

      // R1: decode sweep over every window
      for (int o = 0; o < 'h400; o += 8) begin
         acc(1'b0, o, 4, '0);
         check("R1 decode err", {31'h0, got_err}, {31'h0, !mapped(o)});
      end
      acc(1'b0, 'h32, 1, '0);
      check("R1 align down", got_data, VER[23:16]);
      acc(1'b0, 'h90, 4, '0);
      check("R1 unmapped data", got_data, 32'h0);

      // R2: size and window sweep on the id window
      for (int ln = 0; ln < 8; ln++) begin
         for (int sz = 0; sz < 6; sz++) begin
            acc(1'b0, 'h20 + ln, sz, '0);
            check("R2 size err", {31'h0, got_err},
                  {31'h0, !(sz >= 1 && sz <= 4 && ln + sz <= 8)});
         end
      end
      acc(1'b1, 'hD0, 4, 32'hC3AA_BBCC);
      acc(1'b0, 'hD3, 1, '0);
      check("R2 lane 3 byte", got_data, 32'h0000_00C3);
      acc(1'b0, 'hD2, 2, '0);
      check("R2 lane 2 half", got_data, 32'h0000_C300);
      acc(1'b0, 'hD4, 4, '0);
      check("R2 upper bytes zero", got_data, 32'h0);
      acc(1'b1, 'h80, 1, 32'h5A);
      acc(1'b1, 'h84, 4, 32'hFFFF_FFFF);
      check("R2 upper write ok", {31'h0, got_err}, 32'h0);
      acc(1'b1, 'h86, 4, 32'hFFFF_FFFF);
      check("R2 straddle write err", {31'h0, got_err}, 32'h1);
      acc(1'b0, 'h80, 4, '0);
      check("R2 tpr after lane writes", got_data, 32'h5A);

      // R5
      acc(1'b1, 'h20, 4, 32'hDEAD_BEA5);
      acc(1'b0, 'h20, 4, '0);
      check("R5 id mask", got_data, 32'hA5);
      check("R5 id export", {24'h0, exp_id}, 32'hA5);
      acc(1'b1, 'h21, 1, 32'h77);
      acc(1'b0, 'h20, 4, '0);
      check("R5 id byte1 dropped", got_data, 32'hA5);
      acc(1'b1, 'hD0, 4, 32'hFFFF_FFFF);
      acc(1'b0, 'hD0, 4, '0);
      check("R5 ldr mask", got_data, 32'hFF00_0000);

      // R6
      acc(1'b1, 'hE0, 4, 32'h0);
      acc(1'b0, 'hE0, 4, '0);
      check("R6 dfr fill zero", got_data, 32'h0FFF_FFFF);
      acc(1'b1, 'hE0, 4, 32'hA000_0001);
      check("R6 dfr export", exp_dfr, 32'hAFFF_FFFF);

      // R7
      acc(1'b1, 'h30, 4, 32'hFFFF_FFFF);
      check("R7 version write no err", {31'h0, got_err}, 32'h0);
      acc(1'b0, 'h30, 4, '0);
      check("R7 version kept", got_data, VER);
      acc(1'b1, 'h390, 4, 32'h0);
      cur_count_in = 32'hCAFE_0001;
      acc(1'b0, 'h390, 4, '0);
      check("R7 current count", got_data, 32'hCAFE_0001);

      // R8
      for (int i = 0; i < 6; i++) begin
         acc(1'b1, 'h320 + 16 * i, 4, 32'hFFFF_FFFF);
         acc(1'b0, 'h320 + 16 * i, 4, '0);
         check("R8 lvt ro bits", got_data, 32'hFFFF_AFFF);
      end
      check("R8 lvt export", exp_lvt[32*5 +: 32], 32'hFFFF_AFFF);
      acc(1'b1, 'h340, 2, 32'h0000_0000);
      acc(1'b0, 'h340, 4, '0);
      check("R8 lvt half write", got_data, 32'hFFFF_0000);

      // R9
      acc(1'b1, 'h3E0, 4, 32'hFFFF_FFFF);
      acc(1'b0, 'h3E0, 4, '0);
      check("R9 divide mask", got_data, 32'hB);
      acc(1'b1, 'h380, 4, 32'h8765_4321);
      check("R9 initial count", exp_init, 32'h8765_4321);

      // R10
      acc(1'b1, 'hF0, 4, 32'h0000_01FF);
      check("R10 sw enable set", {31'h0, exp_sw_en}, 32'h1);
      acc(1'b0, 'hF0, 4, '0);
      check("R10 spurious value", got_data, 32'h0000_01FF);
      acc(1'b1, 'hF1, 1, 32'h00);
      check("R10 sw enable clear", {31'h0, exp_sw_en}, 32'h0);

      // R11
      pulse_err(8'h05);
      acc(1'b0, 'h280, 4, '0);
      check("R11 error bits merged", got_data, 32'h05);
      acc(1'b1, 'h280, 4, '0);
      acc(1'b0, 'h280, 4, '0);
      check("R11 first write arms only", got_data, 32'h05);
      acc(1'b1, 'h280, 4, '0);
      acc(1'b0, 'h280, 4, '0);
      check("R11 read cancels arm", got_data, 32'h05);
      acc(1'b1, 'h280, 4, '0);
      acc(1'b1, 'h280, 4, '0);
      acc(1'b0, 'h280, 4, '0);
      check("R11 second write clears", got_data, 32'h0);
      pulse_err(8'h30);
      check("R11 export", {24'h0, exp_esr}, 32'h30);

      // R12
      acc(1'b1, 'hB0, 4, 32'hFFFF_FFFF);
      check("R12 eoi strobe", {31'h0, got_eoi}, 32'h1);
      @(posedge clk); #1;
      check("R12 eoi one cycle", {31'h0, eoi_pulse}, 32'h0);
      acc(1'b0, 'hB0, 4, '0);
      check("R12 eoi reads zero", got_data, 32'h0);
      check("R12 no strobe on read", {31'h0, got_eoi}, 32'h0);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule